// File: doc/BRIEF.md
# Packet-Size Driven Two-Wire Bus Master Sequencer

This block is the bit-level engine of a master-only two-wire (I2C) bus controller. Software, or a DMA engine, places every byte of a packet in a transmit FIFO, including the one or two address bytes. It programs the total number of bytes to send and the number of bytes to receive, then issues a go pulse. The sequencer generates the start condition and shifts each byte out MSB first. It samples the acknowledge slot after every byte. If bit 0 of the first byte (the read flag) is set, it turns the bus around automatically once the transmit count is used up and clocks the receive bytes into a receive FIFO. It then ends the transfer with a stop condition.

SCL and SDA are driven as open-drain enables: an enable of 1 pulls the wire low. The sequencer advances one half bit per pulse of an external bit tick, so a separate divider sets the bus rate. Four protocol events are kept as sticky status bits. A request pulse accompanies every byte moved through a FIFO port, with a separate last-request pulse on the final byte of a packet, so a one-word-burst DMA can keep pace.

Top module: `i2c_pkt_master`

## Requirements
- R1: The first byte popped after a start is sent as the address byte, MSB first. Its bit 0 is the read flag: 0 means the packet is all writes, 1 means reception follows the transmit bytes. A 7-bit address is therefore sent as (addr<<1)|rd.
- R2: The transmit size counts every byte taken from the FIFO, address bytes included. For 10-bit addressing, software supplies 0xF0|(addr[9:8]<<1)|rd followed by addr[7:0], with size 2 for a read. The read flag of the first byte still selects the turnaround.
- R3: After each transmitted byte, the ninth clock samples SDA. A high level is a NACK and sets event bit 0. With stop-on-NACK set, a stop follows at once. With it clear, the packet continues.
- R4: When the transmit size is used up and the read flag is set, event bit 2 (receive switch) is set. Receive-size bytes are then sampled MSB first and pushed to the receive FIFO. The master ACKs every byte except the last, which it NACKs, and then issues a stop.
- R5: Event bit 3 (transmit end) is set when a packet completes by its counts, just before the stop.
- R6: With stop-on-empty set, a stop is issued without a transmit-end event if the FIFO is empty while transmit bytes are still owed. With it clear, the sequencer waits with SCL held low.
- R7: An end-of-data pulse while the bus is held causes a stop at the next byte boundary. In idle it has no effect.
- R8: If SDA reads low while the master releases it during a transmitted bit, event bit 1 (arbitration lost) is set, both wires are released and the sequencer returns to idle without a stop.
- R9: Event bits are sticky until a 1 is written to the matching clear bit. A new event wins over a clear in the same cycle.
- R10: bus_busy_o rises on the cycle after an accepted go and falls after the stop. A go is accepted only in idle with both wires high. While idle, both enables are 0.
- R11: Every FIFO pop or push comes with exactly one request pulse. The pulse is lbreq_o for the final byte of the packet (the last written byte of a write, the last received byte of a read) and breq_o otherwise. A pop happens only with tx_valid_i high.
- R12: After reset the wires are released, the bus is not busy and all event bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-bit pulse from the bus rate divider |
| go_i | input | 1 | Start a packet |
| tx_size_i | input | LEN_W | Bytes to transmit, address bytes included |
| rx_size_i | input | LEN_W | Bytes to receive after the turnaround |
| stop_on_empty_i | input | 1 | Stop when transmit FIFO runs dry |
| stop_on_nack_i | input | 1 | Stop on a NACK |
| end_i | input | 1 | End-of-data command |
| tx_valid_i | input | 1 | Transmit FIFO holds a byte |
| tx_data_i | input | 8 | Transmit FIFO head |
| tx_pop_o | output | 1 | Take the transmit FIFO head |
| rx_push_o | output | 1 | Write rx_data_o to receive FIFO |
| rx_data_o | output | 8 | Received byte |
| sda_i | input | 1 | SDA wire level |
| scl_i | input | 1 | SCL wire level |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| bus_busy_o | output | 1 | Bus held by this master |
| breq_o | output | 1 | Burst request |
| lbreq_o | output | 1 | Last-burst request |
| evt_clr_i | input | 4 | Write-one-to-clear for event bits |
| evt_o | output | 4 | Sticky events: 0 NACK, 1 arbitration lost, 2 receive switch, 3 transmit end |

## Verification
A clear write to an event bit can land in the same cycle as the event that sets that bit. The bench provokes this by holding the transmit-end clear bit high on every cycle of a complete write packet, so the event pulse always meets a clear. It then counts the cycles in which the bit reads 1. Exactly one such cycle must appear: a set-priority latch shows the event for one cycle, while a clear-priority latch would hide it completely.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOAD, ST_TLO, ST_THI, ST_ALO, ST_AHI,
    ST_RLO, ST_RHI, ST_KLO, ST_KHI, ST_P0, ST_P1
  } seq_st_e;
  localparam int EV_NACK  = 0;
  localparam int EV_ARB   = 1;
  localparam int EV_RXSW  = 2;
  localparam int EV_TXEND = 3;
  localparam int EV_N     = 4;
  localparam int BYTE_W   = 8;
endpackage

// File: rtl/i2cs_len_cnt.sv
module i2cs_len_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         one_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - W'(1);
  end
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));
endmodule

// File: rtl/i2cs_evt_reg.sv
module i2cs_evt_reg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    // set wins over a same-cycle clear so no event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign q_o[g] = q;
  end
endmodule

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master
  import i2cs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  logic [LEN_W-1:0]  tx_size_i,
  input  logic [LEN_W-1:0]  rx_size_i,
  input  logic              stop_on_empty_i,
  input  logic              stop_on_nack_i,
  input  logic              end_i,
  input  logic              tx_valid_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              bus_busy_o,
  output logic              breq_o,
  output logic              lbreq_o,
  input  logic [EV_N-1:0]   evt_clr_i,
  output logic [EV_N-1:0]   evt_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  seq_st_e           state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              rd_q, rd_d, first_q, first_d, endp_q, endp_d;
  logic              sda_q, sda_d, scl_q, scl_d;
  logic              cnt_ld, tx_dec, rx_dec, tx_zero, tx_one, rx_zero, rx_one;
  logic              rd_now;
  logic [EV_N-1:0]   evt_set;

  i2cs_len_cnt #(.W(LEN_W)) u_tx_cnt (
    .clk_i, .rst_ni, .load_i(cnt_ld), .val_i(tx_size_i), .dec_i(tx_dec),
    .zero_o(tx_zero), .one_o(tx_one));
  i2cs_len_cnt #(.W(LEN_W)) u_rx_cnt (
    .clk_i, .rst_ni, .load_i(cnt_ld), .val_i(rx_size_i), .dec_i(rx_dec),
    .zero_o(rx_zero), .one_o(rx_one));
  i2cs_evt_reg #(.N(EV_N)) u_evt (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(evt_clr_i), .q_o(evt_o));

  assign rd_now    = first_q ? tx_data_i[0] : rd_q;
  assign rx_data_o = {sh_q[BYTE_W-2:0], sda_i};

  always_comb begin
    state_d = state_q; sh_d = sh_q; bit_d = bit_q; rd_d = rd_q;
    first_d = first_q; sda_d = sda_q; scl_d = scl_q;
    endp_d  = endp_q | (end_i && state_q != ST_IDLE);
    cnt_ld = 1'b0; tx_dec = 1'b0; rx_dec = 1'b0;
    tx_pop_o = 1'b0; rx_push_o = 1'b0; breq_o = 1'b0; lbreq_o = 1'b0;
    evt_set = '0;
    unique case (state_q)
      ST_IDLE: begin
        endp_d = 1'b0;
        if (go_i && sda_i && scl_i) begin
          cnt_ld = 1'b1; first_d = 1'b1; rd_d = 1'b0;
          sda_d = 1'b1; state_d = ST_START;
        end
      end
      ST_START: if (tick_i) begin scl_d = 1'b1; state_d = ST_LOAD; end
      ST_LOAD: begin
        if (endp_q) begin
          sda_d = 1'b1; state_d = ST_P0;
        end else if (tx_zero) begin
          if (rd_q && !rx_zero) begin
            evt_set[EV_RXSW] = 1'b1;
            sda_d = 1'b0; bit_d = BIT_W'(BYTE_W-1); state_d = ST_RLO;
          end else begin
            evt_set[EV_TXEND] = 1'b1;
            sda_d = 1'b1; state_d = ST_P0;
          end
        end else if (tx_valid_i) begin
          tx_pop_o = 1'b1;
          sh_d = tx_data_i; bit_d = BIT_W'(BYTE_W-1);
          sda_d = ~tx_data_i[BYTE_W-1];
          first_d = 1'b0; rd_d = rd_now; state_d = ST_TLO;
          if (tx_one && !rd_now) lbreq_o = 1'b1;
          else                   breq_o  = 1'b1;
        end else if (stop_on_empty_i) begin
          sda_d = 1'b1; state_d = ST_P0;
        end
      end
      ST_TLO: if (tick_i) begin scl_d = 1'b0; state_d = ST_THI; end
      ST_THI: if (tick_i) begin
        if (sh_q[BYTE_W-1] && !sda_i) begin
          evt_set[EV_ARB] = 1'b1;
          sda_d = 1'b0; scl_d = 1'b0; state_d = ST_IDLE;
        end else begin
          scl_d = 1'b1;
          if (bit_q == '0) begin
            sda_d = 1'b0; state_d = ST_ALO;
          end else begin
            sh_d = sh_q << 1; bit_d = bit_q - BIT_W'(1);
            sda_d = ~sh_q[BYTE_W-2]; state_d = ST_TLO;
          end
        end
      end
      ST_ALO: if (tick_i) begin scl_d = 1'b0; state_d = ST_AHI; end
      ST_AHI: if (tick_i) begin
        scl_d = 1'b1; tx_dec = 1'b1; state_d = ST_LOAD;
        if (sda_i) begin
          evt_set[EV_NACK] = 1'b1;
          if (stop_on_nack_i) begin sda_d = 1'b1; state_d = ST_P0; end
        end
      end
      ST_RLO: if (tick_i) begin scl_d = 1'b0; state_d = ST_RHI; end
      ST_RHI: if (tick_i) begin
        scl_d = 1'b1;
        sh_d  = {sh_q[BYTE_W-2:0], sda_i};
        if (bit_q == '0) begin
          rx_push_o = 1'b1; rx_dec = 1'b1;
          sda_d = ~rx_one;          // ACK unless final byte
          state_d = ST_KLO;
          if (rx_one) lbreq_o = 1'b1;
          else        breq_o  = 1'b1;
        end else begin
          bit_d = bit_q - BIT_W'(1); state_d = ST_RLO;
        end
      end
      ST_KLO: if (tick_i) begin scl_d = 1'b0; state_d = ST_KHI; end
      ST_KHI: if (tick_i) begin
        scl_d = 1'b1;
        if (rx_zero) begin
          evt_set[EV_TXEND] = 1'b1; sda_d = 1'b1; state_d = ST_P0;
        end else if (endp_q) begin
          sda_d = 1'b1; state_d = ST_P0;
        end else begin
          sda_d = 1'b0; bit_d = BIT_W'(BYTE_W-1); state_d = ST_RLO;
        end
      end
      ST_P0: if (tick_i) begin scl_d = 1'b0; state_d = ST_P1; end
      ST_P1: if (tick_i) begin sda_d = 1'b0; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; sh_q <= '0; bit_q <= '0; rd_q <= 1'b0;
      first_q <= 1'b0; endp_q <= 1'b0; sda_q <= 1'b0; scl_q <= 1'b0;
    end else begin
      state_q <= state_d; sh_q <= sh_d; bit_q <= bit_d; rd_q <= rd_d;
      first_q <= first_d; endp_q <= endp_d; sda_q <= sda_d; scl_q <= scl_d;
    end
  end

  assign sda_oe_o   = sda_q;
  assign scl_oe_o   = scl_q;
  assign bus_busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       go_i,
  input logic       sda_i,
  input logic       tx_valid_i,
  input logic       tx_pop_o,
  input logic       rx_push_o,
  input logic       breq_o,
  input logic       lbreq_o,
  input logic [3:0] evt_clr_i,
  input logic [3:0] evt_o,
  input logic       bus_busy_o,
  input logic       sda_oe_o,
  input logic       scl_oe_o
);
  assert_pop_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i);
  assert_req_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(breq_o && lbreq_o));
  assert_req_moves_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (breq_o || lbreq_o) |-> (tx_pop_o || rx_push_o));
  assert_dir_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_pop_o && rx_push_o));
  assert_idle_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_busy_o |-> (!sda_oe_o && !scl_oe_o));
  assert_start_cond_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_busy_o) |-> (sda_oe_o && !scl_oe_o));
  assert_go_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !bus_busy_o && !sda_i) |=> !bus_busy_o);
  for (genvar k = 0; k < 4; k++) begin : g_sticky
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[k] && !evt_clr_i[k]) |=> evt_o[k]);
  end
endmodule

bind i2c_pkt_master i2cs_chk u_chk (
  .clk_i, .rst_ni, .go_i, .sda_i, .tx_valid_i, .tx_pop_o, .rx_push_o,
  .breq_o, .lbreq_o, .evt_clr_i, .evt_o, .bus_busy_o, .sda_oe_o, .scl_oe_o
);

// File: tb/sim_i2c_pkt_master.sv
module sim_i2c_pkt_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, tick, go, soe, son, endc;
  logic [7:0] tx_size, rx_size, tx_data, rx_data;
  logic tx_valid, tx_pop, rx_push, sda_oe, scl_oe, busy, breq, lbreq;
  logic [3:0] clr, evt;
  logic sda_line, scl_line, s_pull, force_low;

  int txi, txn, nrxg, nb, nlb, ev3cnt, cyc, tcnt;
  int bitn, bytn, s_ntx, s_nrx, s_nack_at, s_arb_at;
  bit pop_pend, prev_sda, prev_scl, finished;
  logic [7:0] txq [16];
  logic [7:0] seen [16];
  logic [7:0] rdat [16];
  logic [7:0] rxg [16];
  logic       mack [16];
  logic [7:0] cur;
  int errors = 0, nchk = 0;

  assign sda_line = ~(sda_oe | s_pull | force_low);
  assign scl_line = ~scl_oe;
  assign tx_valid = (txi < txn);
  assign tx_data  = txq[txi & 15];

  i2c_pkt_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .go_i(go),
    .tx_size_i(tx_size), .rx_size_i(rx_size),
    .stop_on_empty_i(soe), .stop_on_nack_i(son), .end_i(endc),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data),
    .sda_i(sda_line), .scl_i(scl_line), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe),
    .bus_busy_o(busy), .breq_o(breq), .lbreq_o(lbreq),
    .evt_clr_i(clr), .evt_o(evt));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr10_hi(input logic [9:0] a, input logic r);
    return 8'hF0 | {5'd0, a[9:8], 1'b0} | {7'd0, r};
  endfunction

  // monitor: tick, FIFO bookkeeping, slave model, watchdog
  initial begin
    tcnt = 0; cyc = 0; tick = 1'b0; pop_pend = 1'b0; s_pull = 1'b0;
    prev_sda = 1'b1; prev_scl = 1'b1; bitn = 0; bytn = 0; cur = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, nchk + 1);
        $finish;
      end
      tcnt = (tcnt + 1) % 4;
      tick = (tcnt == 0);
      if (pop_pend) txi++;
      pop_pend = tx_pop;
      if (rx_push && nrxg < 16) begin rxg[nrxg] = rx_data; nrxg++; end
      if (breq) nb++;
      if (lbreq) nlb++;
      if (evt[3]) ev3cnt++;
      if (prev_sda && !sda_line && scl_line && prev_scl) begin
        bitn = 0; bytn = 0;
      end else if (!prev_scl && scl_line) begin
        if (bitn < 8) begin
          cur = {cur[6:0], sda_line}; bitn++;
          if (bitn == 8 && bytn < s_ntx && bytn < 16) seen[bytn] = cur;
        end else begin
          if (bytn >= s_ntx && bytn - s_ntx < 16) mack[bytn - s_ntx] = sda_line;
          bitn = 0; bytn++;
        end
      end else if (prev_scl && !scl_line) begin
        if (bitn == 8)
          s_pull = (bytn < s_ntx) && (bytn != s_nack_at);
        else if (bytn >= s_ntx && bytn < s_ntx + s_nrx)
          s_pull = ~rdat[(bytn - s_ntx) & 15][7 - bitn];
        else
          s_pull = (bytn == 0 && bitn == s_arb_at);
      end
      prev_sda = sda_line; prev_scl = scl_line;
    end
  end

  task automatic clear_evt();
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = 4'h0;
  endtask

  task automatic run(input int ntx, input int nrx, input int nfifo,
                     input bit soe_v, input bit son_v,
                     input int nack_at, input int arb_at, input bit do_end);
    @(negedge clk);
    txn = nfifo; txi = 0; pop_pend = 1'b0; nrxg = 0; nb = 0; nlb = 0;
    s_ntx = ntx; s_nrx = nrx; s_nack_at = nack_at; s_arb_at = arb_at;
    s_pull = 1'b0; bitn = 0; bytn = 0;
    tx_size = 8'(ntx); rx_size = 8'(nrx); soe = soe_v; son = son_v;
    go = 1'b1;
    @(negedge clk); go = 1'b0;
    chk("R10 busy after go", int'(busy), 1);
    if (do_end) begin
      repeat (300) @(negedge clk);
      chk("R7 waits on empty FIFO", int'(busy), 1);
      endc = 1'b1;
      @(negedge clk); endc = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    s_pull = 1'b0;
  endtask

  initial begin
    logic [7:0] a;
    logic [9:0] a10;
    finished = 0; rst_n = 1'b0; go = 0; soe = 0; son = 0; endc = 0; clr = '0;
    tx_size = '0; rx_size = '0; force_low = 0; txn = 0; txi = 0;
    s_ntx = 0; s_nrx = 0; s_nack_at = -1; s_arb_at = -1; nrxg = 0; ev3cnt = 0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R12 sda released", int'(sda_oe), 0);
    chk("R12 scl released", int'(scl_oe), 0);
    chk("R12 not busy", int'(busy), 0);
    chk("R12 events clear", int'(evt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R5 R11: 7-bit write
    txq[0] = 8'hA0;
    for (int i = 1; i < 4; i++) txq[i] = 8'($urandom);
    run(4, 0, 4, 1, 1, -1, -1, 0);
    for (int i = 0; i < 4; i++) chk("R1 R3 byte on wire", int'(seen[i]), int'(txq[i]));
    chk("R5 txend only", int'(evt), 4'b1000);
    chk("R11 breq write", nb, 3);
    chk("R11 lbreq write", nlb, 1);
    chk("R10 idle lines", int'({sda_oe, scl_oe, busy}), 0);
    clear_evt();
    chk("R9 cleared by ones", int'(evt), 0);

    // R4: 7-bit read of 3
    txq[0] = 8'hA1;
    for (int i = 0; i < 3; i++) rdat[i] = 8'($urandom);
    run(1, 3, 1, 1, 1, -1, -1, 0);
    chk("R4 rx count", nrxg, 3);
    for (int i = 0; i < 3; i++) chk("R4 rx byte", int'(rxg[i]), int'(rdat[i]));
    chk("R4 ack 0", int'(mack[0]), 0);
    chk("R4 ack 1", int'(mack[1]), 0);
    chk("R4 nack last", int'(mack[2]), 1);
    chk("R4 R5 rxsw+txend", int'(evt), 4'b1100);
    chk("R11 breq read", nb, 3);
    chk("R11 lbreq read", nlb, 1);
    clear_evt();

    // R2: 10-bit read
    a10 = 10'h2B4;
    txq[0] = addr10_hi(a10, 1'b1); txq[1] = a10[7:0];
    rdat[0] = 8'h5A; rdat[1] = 8'hC3;
    run(2, 2, 2, 1, 1, -1, -1, 0);
    chk("R2 hi addr byte", int'(seen[0]), 8'hF5);
    chk("R2 lo addr byte", int'(seen[1]), 8'hB4);
    chk("R2 rx byte0", int'(rxg[0]), 8'h5A);
    chk("R2 rx byte1", int'(rxg[1]), 8'hC3);
    chk("R2 events", int'(evt), 4'b1100);
    clear_evt();

    // R3: NACK with stop
    txq[0] = 8'h90; txq[1] = 8'h11; txq[2] = 8'h22; txq[3] = 8'h33;
    run(4, 0, 4, 1, 1, 1, -1, 0);
    chk("R3 nack stops", bytn, 2);
    chk("R3 nack event", int'(evt), 4'b0001);
    clear_evt();
    // R3: NACK without stop
    run(4, 0, 4, 1, 0, 1, -1, 0);
    chk("R3 nack continues", bytn, 4);
    chk("R3 nack+txend", int'(evt), 4'b1001);
    clear_evt();

    // R6: stop on empty
    run(4, 0, 2, 1, 1, -1, -1, 0);
    chk("R6 early stop bytes", bytn, 2);
    chk("R6 no event", int'(evt), 0);
    chk("R6 released", int'(busy), 0);

    // R7: end command while waiting on empty FIFO
    run(4, 0, 2, 0, 1, -1, -1, 1);
    chk("R7 bytes before end", bytn, 2);
    chk("R7 no event", int'(evt), 0);
    chk("R7 released", int'({sda_oe, scl_oe, busy}), 0);
    // R7: end in idle ignored
    @(negedge clk); endc = 1'b1; @(negedge clk); endc = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 idle end lines", int'({sda_oe, scl_oe, busy}), 0);
    run(4, 0, 4, 1, 1, -1, -1, 0);
    chk("R7 idle end no effect", bytn, 4);
    clear_evt();

    // R8: arbitration lost on bit 2 of 0xFE
    txq[0] = 8'hFE;
    run(1, 0, 1, 1, 1, -1, 2, 0);
    chk("R8 arb event", int'(evt), 4'b0010);
    chk("R8 released", int'({sda_oe, scl_oe, busy}), 0);
    clear_evt();

    // R9: clear held on every cycle while txend fires
    clr = 4'b1000; ev3cnt = 0;
    txq[0] = 8'h42; txq[1] = 8'h99;
    run(2, 0, 2, 1, 1, -1, -1, 0);
    chk("R9 set wins over clear", ev3cnt, 1);
    clr = 4'b0000;
    @(negedge clk);
    chk("R9 cleared after", int'(evt), 0);

    // R10: go ignored while SDA held low
    force_low = 1'b1;
    @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 go blocked", int'(busy), 0);
    force_low = 1'b0;
    repeat (2) @(negedge clk);

    // random packets
    for (int it = 0; it < 6; it++) begin
      automatic bit rdx = 1'($urandom);
      automatic int nt = rdx ? 1 : 1 + int'($urandom % 4);
      automatic int nr = rdx ? 1 + int'($urandom % 4) : 0;
      a = {7'($urandom), rdx};
      txq[0] = a;
      for (int i = 1; i < nt; i++) txq[i] = 8'($urandom);
      for (int i = 0; i < nr; i++) rdat[i] = 8'($urandom);
      run(nt, nr, nt, 1, 1, -1, -1, 0);
      if (rdx) begin
        for (int i = 0; i < nr; i++) chk("R4 random rx", int'(rxg[i]), int'(rdat[i]));
        chk("R4 random events", int'(evt), 4'b1100);
        chk("R11 random breq", nb, nr);
      end else begin
        for (int i = 0; i < nt; i++) chk("R1 random tx", int'(seen[i]), int'(txq[i]));
        chk("R5 random events", int'(evt), 4'b1000);
        chk("R11 random breq", nb, nt - 1);
      end
      chk("R11 random lbreq", nlb, 1);
      clear_evt();
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, nchk);
    $finish;
  end
endmodule